// File: doc/BRIEF.md
# Three-Level Privilege Mode Controller with Banked Registers

This block tracks the privilege level of a small 16-bit processor and owns one register file per level. There are three levels: user, system and interrupt. A software trap raised in user level moves the core to system level; a hardware interrupt request moves it from user or system level to interrupt level. Because every level has its own register file, the switch takes effect on the next clock edge and nothing is copied or saved. The register file that was left keeps its contents, so a return continues with the same register values as before.

System level stays open to interrupts. A system call that waits for an interrupt to finish can therefore not lock up the core. Interrupts are held off only while the core is at interrupt level. A request that arrives then is latched and is accepted once the core has returned. The instruction decoder, the vector address logic and the memory path live outside this block. The block reports the current level and a one-hot acknowledge of the line being accepted, which the vector logic uses.

Top module: `mode_bank_ctrl`

## Requirements
- R1: After reset the level output `cur_mode` is 1 (system), `irq_ack` is 0, no interrupt or trap is pending, and every register of every bank reads 0. Level encoding on `cur_mode`: 0 = user, 1 = system, 2 = interrupt.
- R2: `rd_data` shows register `rd_addr` of the bank that belongs to the current level, with no clock delay. A write with `wr_en` high stores `wr_data` at `wr_addr` in the current level's bank at the clock edge. The value is visible on the next cycle.
- R3: A write changes only the bank of the level that is current at that edge. The other two banks keep their contents through any number of level changes.
- R4: `trap_req` sampled high in user level, with no interrupt accepted at the same edge, gives system level on the next cycle. `trap_req` in system or interrupt level has no effect.
- R5: In user or system level, an interrupt request moves the core to interrupt level at the next edge. A request is any line of `irq_lines` sampled high, or any latched one. At the same edge `irq_ack` shows, for one cycle, the one-hot bit of the accepted line.
- R6: While the core is at interrupt level, no request is accepted. The level stays at interrupt until `ret_strobe`, and `irq_ack` stays 0.
- R7: Each line sampled high and not accepted at that edge is latched. A latched request is accepted on the first edge at which the core is not at interrupt level. Its latch is cleared when it is accepted.
- R8: `ret_strobe` at interrupt level returns to the level that was interrupted (user or system). At system level it returns to user level, unless an interrupt is accepted at that edge, in which case the strobe is dropped. At user level it has no effect.
- R9: When several requests compete, the lowest-numbered line (bit 0 first) is accepted. Only its latch is cleared, and the others are taken one per return in ascending order.
- R10: If a trap and an interrupt coincide in user level, the interrupt is taken. The trap is held, and it moves the core to system level on the first edge after the return to user level at which no interrupt is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 3 | Read register index in the current bank |
| rd_data | output | 16 | Read data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Write register index in the current bank |
| wr_data | input | 16 | Write data |
| trap_req | input | 1 | Software trap or system call request |
| irq_lines | input | 4 | Hardware interrupt request lines, bit 0 highest priority |
| ret_strobe | input | 1 | Return-from-trap strobe |
| cur_mode | output | 2 | Current level: 0 user, 1 system, 2 interrupt |
| irq_ack | output | 4 | One-hot acknowledge of the line accepted, one cycle |

## Verification
The bench sweeps all fifteen non-empty request patterns twice: once entered from user level with the lines raised together, and once latched while the core is already at interrupt level above system. It then follows each pattern through one return per line. A design with a wrong priority encoder would acknowledge a higher line first. A design that cleared all latches on acceptance would stop after the first return. One that accepted requests at interrupt level would show a nonzero acknowledge while nested. One that forgot the interrupted level would come back to user instead of system. Distinct values written into each bank are read back after each level change, which catches a write or a read steered to the wrong bank. A coincident trap and interrupt shows whether the trap is lost or taken too early.

// File: rtl/modebank_pkg.sv
package modebank_pkg;
   typedef enum logic [1:0] {
      MODE_USER = 2'd0,
      MODE_SYS  = 2'd1,
      MODE_IRQ  = 2'd2
   } mode_t;
   localparam int NUM_MODES = 3;
endpackage

// File: rtl/mb_reg_bank.sv
module mb_reg_bank #(
   parameter int DATA_W  = 16,
   parameter int REG_CNT = 8,
   localparam int AW     = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [REG_CNT-1:0][DATA_W-1:0] regs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs <= '0;
      else if (we) regs[waddr] <= wdata;
   end

   assign rdata = regs[raddr];

   // R3: a bank that is not written holds every register
   p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(regs));
   // R2: a write lands at the addressed register
   p_bank_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mb_irq_latch.sv
module mb_irq_latch #(
   parameter int IRQ_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IRQ_LINES-1:0] irq_lines,
   input  logic                 accept_ok,
   output logic                 irq_take,
   output logic [IRQ_LINES-1:0] irq_ack
);
   logic [IRQ_LINES-1:0] pend, req, grant;

   assign req      = pend | irq_lines;
   assign irq_take = accept_ok && (req != '0);
   assign grant    = irq_take ? (req & (~req + IRQ_LINES'(1))) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= '0;
         irq_ack <= '0;
      end else begin
         pend    <= req & ~grant;
         irq_ack <= grant;
      end
   end

   // R5: acknowledge names at most one line
   p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));
   // R6: nothing accepted while acceptance is closed
   p_no_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !accept_ok |=> irq_ack == '0);
   // R9: accepted line was requesting and no lower line was
   p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0) |-> ((($past(req) & (irq_ack - IRQ_LINES'(1))) == '0)
                           && (($past(req) & irq_ack) != '0)));
endmodule

// File: rtl/mb_mode_fsm.sv
module mb_mode_fsm
   import modebank_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  trap_req,
   input  logic  ret_strobe,
   input  logic  irq_take,
   output mode_t mode
);
   mode_t saved;
   logic  trap_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= MODE_SYS;
         saved     <= MODE_USER;
         trap_pend <= 1'b0;
      end else if (irq_take) begin
         mode  <= MODE_IRQ;
         saved <= mode;
         if (mode == MODE_USER && trap_req) trap_pend <= 1'b1;
      end else begin
         case (mode)
            MODE_USER: if (trap_req || trap_pend) begin
               mode      <= MODE_SYS;
               trap_pend <= 1'b0;
            end
            MODE_SYS:  if (ret_strobe) mode <= MODE_USER;
            MODE_IRQ:  if (ret_strobe) mode <= saved;
            default:   mode <= MODE_SYS;
         endcase
      end
   end

   // R1: only the three defined levels occur
   p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);
   // R6: interrupt level is left only by a return
   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_IRQ && !ret_strobe) |=> mode == MODE_IRQ);
   // R8: return from interrupt level leaves it
   p_irq_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_IRQ && ret_strobe) |=> mode != MODE_IRQ);
   // R4: a trap in user level enters system level
   p_trap_sys_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_USER && trap_req && !irq_take) |=> mode == MODE_SYS);
   // R10: interrupt beats a coincident trap
   p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_USER && trap_req && irq_take) |=> mode == MODE_IRQ);
endmodule

// File: rtl/mode_bank_ctrl.sv
module mode_bank_ctrl
   import modebank_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int REG_CNT   = 8,
   parameter int IRQ_LINES = 4,
   localparam int AW       = $clog2(REG_CNT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 trap_req,
   input  logic [IRQ_LINES-1:0] irq_lines,
   input  logic                 ret_strobe,
   output logic [1:0]           cur_mode,
   output logic [IRQ_LINES-1:0] irq_ack
);
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (REG_CNT < 2 || (REG_CNT & (REG_CNT - 1)) != 0) begin : g_bad_depth
      $error("REG_CNT must be a power of two, at least 2");
   end
   if (IRQ_LINES < 1) begin : g_bad_lines
      $error("IRQ_LINES must be at least 1");
   end

   mode_t             mode;
   logic              irq_take;
   logic [DATA_W-1:0] bank_rd [4];

   mb_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap_req   (trap_req),
      .ret_strobe (ret_strobe),
      .irq_take   (irq_take),
      .mode       (mode)
   );

   mb_irq_latch #(.IRQ_LINES(IRQ_LINES)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_lines (irq_lines),
      .accept_ok (mode != MODE_IRQ),
      .irq_take  (irq_take),
      .irq_ack   (irq_ack)
   );

   for (genvar b = 0; b < NUM_MODES; b++) begin : g_bank
      mb_reg_bank #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && (mode == mode_t'(b))),
         .waddr (wr_addr),
         .wdata (wr_data),
         .raddr (rd_addr),
         .rdata (bank_rd[b])
      );
   end
   for (genvar u = NUM_MODES; u < 4; u++) begin : g_unused
      assign bank_rd[u] = '0;
   end

   assign rd_data  = bank_rd[mode];
   assign cur_mode = mode;

   // R5: an acknowledge coincides with interrupt level
   p_ack_in_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0) |-> cur_mode == 2'd2);
endmodule

// File: tb/tb_mode_bank_ctrl.sv
module tb_mode_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        trap_req = 1'b0;
   logic [3:0]  irq_lines = '0;
   logic        ret_strobe = 1'b0;
   logic [1:0]  cur_mode;
   logic [3:0]  irq_ack;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   mode_bank_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .trap_req(trap_req), .irq_lines(irq_lines), .ret_strobe(ret_strobe),
      .cur_mode(cur_mode), .irq_ack(irq_ack)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic tr, input logic [3:0] irq, input logic rt);
      trap_req = tr; irq_lines = irq; ret_strobe = rt;
      @(posedge clk); #2;
      trap_req = 1'b0; irq_lines = '0; ret_strobe = 1'b0;
   endtask

   task automatic wreg(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic rchk(input string tag, input logic [2:0] a, input logic [15:0] exp);
      rd_addr = a; #1;
      chk(tag, rd_data, exp);
   endtask

   function automatic logic [15:0] val(input int m, input int k);
      return 16'(16'h1000 * (m + 1) + 16'h0111 * k);
   endfunction

   function automatic logic [3:0] lowest(input logic [3:0] x);
      return x & (~x + 4'd1);
   endfunction

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [3:0] rem;
      logic [3:0] lo;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      chk("R1 mode", cur_mode, 2'd1);
      chk("R1 ack", irq_ack, 4'd0);
      for (int k = 0; k < 8; k++) rchk("R1 reg", 3'(k), 16'h0);
      cyc(0, 4'd0, 0);
      chk("R1 no pending", cur_mode, 2'd1);

      // R2 per-bank writes
      for (int k = 0; k < 8; k++) wreg(3'(k), val(1, k));
      cyc(0, 4'd0, 1);
      chk("R8 sys ret to user", cur_mode, 2'd0);
      for (int k = 0; k < 8; k++) rchk("R3 user bank untouched", 3'(k), 16'h0);
      for (int k = 0; k < 8; k++) wreg(3'(k), val(0, k));
      for (int k = 0; k < 8; k++) rchk("R2 user readback", 3'(k), val(0, k));
      cyc(0, 4'd1, 0);
      chk("R5 enter irq", cur_mode, 2'd2);
      chk("R5 ack line0", irq_ack, 4'd1);
      for (int k = 0; k < 8; k++) wreg(3'(k), val(2, k));
      for (int k = 0; k < 8; k++) rchk("R2 irq readback", 3'(k), val(2, k));
      cyc(0, 4'd0, 1);
      chk("R8 irq ret to user", cur_mode, 2'd0);
      for (int k = 0; k < 8; k++) rchk("R3 user kept", 3'(k), val(0, k));
      cyc(1, 4'd0, 0);
      chk("R4 trap to sys", cur_mode, 2'd1);
      for (int k = 0; k < 8; k++) rchk("R3 sys kept", 3'(k), val(1, k));
      cyc(1, 4'd0, 0);
      chk("R4 trap ignored in sys", cur_mode, 2'd1);
      cyc(0, 4'd8, 0);
      chk("R5 irq from sys", cur_mode, 2'd2);
      chk("R5 ack line3", irq_ack, 4'd8);
      for (int k = 0; k < 8; k++) rchk("R3 irq kept", 3'(k), val(2, k));
      cyc(1, 4'd0, 0);
      chk("R4 trap ignored in irq", cur_mode, 2'd2);
      cyc(0, 4'd0, 1);
      chk("R8 irq ret to sys", cur_mode, 2'd1);
      cyc(0, 4'd0, 1);
      chk("R8 sys ret to user", cur_mode, 2'd0);
      cyc(0, 4'd0, 1);
      chk("R8 ret ignored in user", cur_mode, 2'd0);
      for (int k = 0; k < 8; k++) rchk("R8 user regs after ignored ret", 3'(k), val(0, k));

      // R9 / R7 sweep from user level
      for (int p = 1; p < 16; p++) begin
         lo = lowest(4'(p));
         cyc(0, 4'(p), 0);
         chk("R5 sweep enter", cur_mode, 2'd2);
         chk("R9 sweep first ack", irq_ack, lo);
         rem = 4'(p) & ~lo;
         cyc(0, 4'd0, 0);
         chk("R6 stay irq", cur_mode, 2'd2);
         chk("R6 ack pulse", irq_ack, 4'd0);
         while (rem != 4'd0) begin
            cyc(0, 4'd0, 1);
            chk("R8 back to user", cur_mode, 2'd0);
            lo = lowest(rem);
            cyc(0, 4'd0, 0);
            chk("R7 latched taken", cur_mode, 2'd2);
            chk("R9 next lowest", irq_ack, lo);
            rem = rem & ~lo;
         end
         cyc(0, 4'd0, 1);
         chk("R8 final ret", cur_mode, 2'd0);
         cyc(0, 4'd0, 0);
         chk("R7 latch cleared", cur_mode, 2'd0);
      end

      // R6 / R7 sweep: requests latched while nested above system
      cyc(1, 4'd0, 0);
      chk("R4 trap to sys", cur_mode, 2'd1);
      for (int p = 1; p < 16; p++) begin
         cyc(0, 4'd8, 0);
         chk("R5 enter from sys", irq_ack, 4'd8);
         cyc(0, 4'(p), 0);
         chk("R6 no accept in irq", irq_ack, 4'd0);
         chk("R6 still irq", cur_mode, 2'd2);
         rem = 4'(p);
         while (rem != 4'd0) begin
            cyc(0, 4'd0, 1);
            chk("R8 back to sys", cur_mode, 2'd1);
            lo = lowest(rem);
            cyc(0, 4'd0, 0);
            chk("R7 latched taken from sys", cur_mode, 2'd2);
            chk("R9 order from sys", irq_ack, lo);
            rem = rem & ~lo;
         end
         cyc(0, 4'd0, 1);
         chk("R8 final ret sys", cur_mode, 2'd1);
         cyc(0, 4'd0, 0);
         chk("R7 none left", cur_mode, 2'd1);
      end

      // R10 coincident trap and interrupt
      cyc(0, 4'd0, 1);
      chk("R8 sys ret to user", cur_mode, 2'd0);
      cyc(1, 4'd2, 0);
      chk("R10 irq wins", cur_mode, 2'd2);
      chk("R10 ack line1", irq_ack, 4'd2);
      cyc(0, 4'd0, 1);
      chk("R10 back to user", cur_mode, 2'd0);
      cyc(0, 4'd0, 0);
      chk("R10 held trap taken", cur_mode, 2'd1);
      for (int k = 0; k < 8; k++) rchk("R3 sys bank at end", 3'(k), val(1, k));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule